// File: doc/BRIEF.md
# Predicate Register File with Equality Compare

This block holds the one-bit guard flags of a predicated-execution pipeline together with the units that set them. Each cycle, up to four compare operations may arrive. Each one carries two operand words and two destination flag indices. When the operands are equal, the first destination receives 1 and the second receives 0. When they differ, the values are swapped.

Flag zero is hard-wired true and cannot be written. A compare can therefore use it as a destination to throw away the result it does not need. It is also the guard of instructions that must always execute.

Four read ports return flag values. Each read port also has an issue-valid input and produces a commit enable. A guarded instruction takes effect only when its guard flag is true. Otherwise it behaves as a no-op.

Top module: `pred_cmp_rf`

## Requirements
- R1: A valid compare on any port writes (a == b) into its true-destination flag and the complement into its false-destination flag. The new values are readable from the cycle after the clock edge that accepts the compare.
- R2: Flag index 0 always reads as 1. Any compare result aimed at index 0 is discarded.
- R3: commit_en_o[k] is 1 only when issue_valid_i[k] is 1 and the flag selected by rd_idx_i[k] is 1. In every other case it is 0.
- R4: Up to four compares with distinct destinations may be accepted in the same cycle. Each of them updates its own two flags.
- R5: When several destinations in one cycle name the same flag, two rules decide which value is stored:
  - Between ports, the lowest-numbered port wins.
  - Within a single port, the true destination wins over the false destination.
- R6: After rst_ni is asserted low, flags 1 to 63 read as 0 and flag 0 reads as 1.
- R7: A read in the same cycle as a write to the same flag returns the value held before that write.
- R8: A flag that no valid compare targets keeps its value. In a cycle with no valid compare, no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_valid_i | input | 4 | Per-port compare valid |
| cmp_a_i | input | 4x32 | First operand per port |
| cmp_b_i | input | 4x32 | Second operand per port |
| cmp_dst_t_i | input | 4x6 | Flag index that receives the equal result |
| cmp_dst_f_i | input | 4x6 | Flag index that receives the complement |
| rd_idx_i | input | 4x6 | Guard flag index per read port |
| issue_valid_i | input | 4 | Instruction present on the read port |
| rd_val_o | output | 4 | Value of the selected flag |
| commit_en_o | output | 4 | Commit enable for the guarded instruction |

## Verification
The assertions are checked on every cycle. They cover three groups of behaviour:
- Flag zero always reads as true, and the commit enable never rises without a valid issue and a true guard.
- After any compare on port 0, the flags it targeted hold its results. Because port 0 has top priority, this holds even when other ports collide with it.
- A cycle with no compare leaves the whole flag vector unchanged.

Only the bench scenarios can show the rest:
- the reset values;
- read-before-write in the same cycle;
- four simultaneous updates;
- the resolution between ports and within a port when destinations collide.

// File: rtl/pred_cmp_pkg.sv
package pred_cmp_pkg;
  localparam int unsigned PRED_NUM_DEF = 64;
  localparam int unsigned WR_PORTS_DEF = 4;
  localparam int unsigned RD_PORTS_DEF = 4;
  localparam int unsigned DATA_W_DEF   = 32;

  // reset image: flag 0 true, all others false
  function automatic logic [PRED_NUM_DEF-1:0] pred_reset_vec();
    logic [PRED_NUM_DEF-1:0] v;
    v    = '0;
    v[0] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pred_eq_cmp.sv
module pred_eq_cmp #(
  parameter int unsigned WR_PORTS = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic [WR_PORTS-1:0][DATA_W-1:0] a_i,
  input  logic [WR_PORTS-1:0][DATA_W-1:0] b_i,
  output logic [WR_PORTS-1:0]             eq_o
);
  for (genvar p = 0; p < WR_PORTS; p++) begin : g_cmp
    assign eq_o[p] = (a_i[p] == b_i[p]);
  end
endmodule

// File: rtl/pred_wr_resolve.sv
module pred_wr_resolve #(
  parameter int unsigned PRED_NUM = 64,
  parameter int unsigned WR_PORTS = 4,
  localparam int unsigned IDX_W   = $clog2(PRED_NUM)
) (
  input  logic [PRED_NUM-1:0]             cur_i,
  input  logic [WR_PORTS-1:0]             valid_i,
  input  logic [WR_PORTS-1:0]             eq_i,
  input  logic [WR_PORTS-1:0][IDX_W-1:0]  dst_t_i,
  input  logic [WR_PORTS-1:0][IDX_W-1:0]  dst_f_i,
  output logic [PRED_NUM-1:0]             nxt_o
);
  // apply highest port first so lower ports overwrite; true dest last in a port
  always_comb begin
    nxt_o = cur_i;
    for (int p = WR_PORTS - 1; p >= 0; p--) begin
      if (valid_i[p]) begin
        nxt_o[dst_f_i[p]] = ~eq_i[p];
        nxt_o[dst_t_i[p]] = eq_i[p];
      end
    end
    nxt_o[0] = 1'b1;
  end
endmodule

// File: rtl/pred_store.sv
module pred_store #(
  parameter int unsigned PRED_NUM = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [PRED_NUM-1:0] nxt_i,
  output logic [PRED_NUM-1:0] q_o
);
  localparam logic [PRED_NUM-1:0] RST_VAL = {{(PRED_NUM-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= nxt_i;
  end
endmodule

// File: rtl/pred_read_gate.sv
module pred_read_gate #(
  parameter int unsigned PRED_NUM = 64,
  parameter int unsigned RD_PORTS = 4,
  localparam int unsigned IDX_W   = $clog2(PRED_NUM)
) (
  input  logic [PRED_NUM-1:0]            q_i,
  input  logic [RD_PORTS-1:0][IDX_W-1:0] idx_i,
  input  logic [RD_PORTS-1:0]            issue_valid_i,
  output logic [RD_PORTS-1:0]            val_o,
  output logic [RD_PORTS-1:0]            commit_en_o
);
  for (genvar k = 0; k < RD_PORTS; k++) begin : g_rd
    assign val_o[k]       = (idx_i[k] == '0) ? 1'b1 : q_i[idx_i[k]];
    assign commit_en_o[k] = issue_valid_i[k] & val_o[k];
  end
endmodule

// File: rtl/pred_cmp_rf.sv
module pred_cmp_rf #(
  parameter int unsigned PRED_NUM = pred_cmp_pkg::PRED_NUM_DEF,
  parameter int unsigned WR_PORTS = pred_cmp_pkg::WR_PORTS_DEF,
  parameter int unsigned RD_PORTS = pred_cmp_pkg::RD_PORTS_DEF,
  parameter int unsigned DATA_W   = pred_cmp_pkg::DATA_W_DEF,
  localparam int unsigned IDX_W   = $clog2(PRED_NUM)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [WR_PORTS-1:0]             cmp_valid_i,
  input  logic [WR_PORTS-1:0][DATA_W-1:0] cmp_a_i,
  input  logic [WR_PORTS-1:0][DATA_W-1:0] cmp_b_i,
  input  logic [WR_PORTS-1:0][IDX_W-1:0]  cmp_dst_t_i,
  input  logic [WR_PORTS-1:0][IDX_W-1:0]  cmp_dst_f_i,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx_i,
  input  logic [RD_PORTS-1:0]             issue_valid_i,
  output logic [RD_PORTS-1:0]             rd_val_o,
  output logic [RD_PORTS-1:0]             commit_en_o
);
  logic [WR_PORTS-1:0] eq;
  logic [PRED_NUM-1:0] pred_q;
  logic [PRED_NUM-1:0] pred_d;

  pred_eq_cmp #(.WR_PORTS(WR_PORTS), .DATA_W(DATA_W)) u_cmp (
    .a_i  (cmp_a_i),
    .b_i  (cmp_b_i),
    .eq_o (eq)
  );

  pred_wr_resolve #(.PRED_NUM(PRED_NUM), .WR_PORTS(WR_PORTS)) u_res (
    .cur_i   (pred_q),
    .valid_i (cmp_valid_i),
    .eq_i    (eq),
    .dst_t_i (cmp_dst_t_i),
    .dst_f_i (cmp_dst_f_i),
    .nxt_o   (pred_d)
  );

  pred_store #(.PRED_NUM(PRED_NUM)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (|cmp_valid_i),
    .nxt_i  (pred_d),
    .q_o    (pred_q)
  );

  pred_read_gate #(.PRED_NUM(PRED_NUM), .RD_PORTS(RD_PORTS)) u_rd (
    .q_i           (pred_q),
    .idx_i         (rd_idx_i),
    .issue_valid_i (issue_valid_i),
    .val_o         (rd_val_o),
    .commit_en_o   (commit_en_o)
  );
endmodule

// File: rtl/pred_cmp_rf_chk.sv
module pred_cmp_rf_chk #(
  parameter int unsigned PRED_NUM = 64,
  parameter int unsigned WR_PORTS = 4,
  parameter int unsigned RD_PORTS = 4,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = $clog2(PRED_NUM)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [WR_PORTS-1:0]             cmp_valid_i,
  input logic [WR_PORTS-1:0][DATA_W-1:0] cmp_a_i,
  input logic [WR_PORTS-1:0][DATA_W-1:0] cmp_b_i,
  input logic [WR_PORTS-1:0][IDX_W-1:0]  cmp_dst_t_i,
  input logic [WR_PORTS-1:0][IDX_W-1:0]  cmp_dst_f_i,
  input logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx_i,
  input logic [RD_PORTS-1:0]             issue_valid_i,
  input logic [RD_PORTS-1:0]             rd_val_o,
  input logic [RD_PORTS-1:0]             commit_en_o,
  input logic [PRED_NUM-1:0]             pred_q
);
  // port 0 has top priority, so its targets must hold its result next cycle
  logic             t_fire_q, f_fire_q, eq_q;
  logic [IDX_W-1:0] t_idx_q, f_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_fire_q <= 1'b0;
      f_fire_q <= 1'b0;
      eq_q     <= 1'b0;
      t_idx_q  <= '0;
      f_idx_q  <= '0;
    end else begin
      t_fire_q <= cmp_valid_i[0] && (cmp_dst_t_i[0] != '0);
      f_fire_q <= cmp_valid_i[0] && (cmp_dst_f_i[0] != '0) && (cmp_dst_f_i[0] != cmp_dst_t_i[0]);
      eq_q     <= (cmp_a_i[0] == cmp_b_i[0]);
      t_idx_q  <= cmp_dst_t_i[0];
      f_idx_q  <= cmp_dst_f_i[0];
    end
  end

  AST_P0_TRUE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_fire_q |-> (pred_q[t_idx_q] == eq_q)); // R1
  AST_P0_FALSE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_fire_q |-> (pred_q[f_idx_q] == !eq_q)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i == '0) |=> $stable(pred_q)); // R8

  for (genvar k = 0; k < RD_PORTS; k++) begin : g_rd_chk
    AST_ZERO_READS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_idx_i[k] == '0) |-> rd_val_o[k]); // R2
    AST_NO_COMMIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !issue_valid_i[k] |-> !commit_en_o[k]); // R3
    AST_COMMIT_NEEDS_TRUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_en_o[k] |-> rd_val_o[k]); // R3
  end
endmodule

bind pred_cmp_rf pred_cmp_rf_chk #(
  .PRED_NUM(PRED_NUM), .WR_PORTS(WR_PORTS), .RD_PORTS(RD_PORTS), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmp_valid_i(cmp_valid_i), .cmp_a_i(cmp_a_i),
  .cmp_b_i(cmp_b_i), .cmp_dst_t_i(cmp_dst_t_i), .cmp_dst_f_i(cmp_dst_f_i),
  .rd_idx_i(rd_idx_i), .issue_valid_i(issue_valid_i), .rd_val_o(rd_val_o),
  .commit_en_o(commit_en_o), .pred_q(pred_q)
);

// File: tb/pred_cmp_rf_test.sv
module pred_cmp_rf_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 64, NW = 4, NR = 4, DW = 32, IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0]         cmp_valid;
  logic [NW-1:0][DW-1:0] cmp_a, cmp_b;
  logic [NW-1:0][IW-1:0] dst_t, dst_f;
  logic [NR-1:0][IW-1:0] rd_idx;
  logic [NR-1:0]         issue_valid;
  logic [NR-1:0]         rd_val, commit_en;

  int n_chk = 0;
  int n_bad = 0;
  bit model [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_cmp_rf uut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_valid_i(cmp_valid), .cmp_a_i(cmp_a),
    .cmp_b_i(cmp_b), .cmp_dst_t_i(dst_t), .cmp_dst_f_i(dst_f), .rd_idx_i(rd_idx),
    .issue_valid_i(issue_valid), .rd_val_o(rd_val), .commit_en_o(commit_en)
  );

  // {a, b, dst_t, dst_f}
  localparam logic [75:0] VEC [8] = '{
    {32'h5,        32'h5,        6'd1,  6'd2},
    {32'h5,        32'h6,        6'd1,  6'd2},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 6'd63, 6'd62},
    {32'h0,        32'h80000000, 6'd10, 6'd0},
    {32'h1234,     32'h1234,     6'd11, 6'd0},
    {32'h7,        32'h7,        6'd0,  6'd12},
    {32'h7,        32'h8,        6'd0,  6'd12},
    {32'hAAAA,     32'hAAAB,     6'd63, 6'd20}
  };

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic logic read_now(input int idx);
    return 1'b0;
  endfunction

  task automatic rd(input int idx, output logic v);
    rd_idx[3] = IW'(idx);
    #1;
    v = rd_val[3];
  endtask

  task automatic idle_inputs();
    cmp_valid = '0; cmp_a = '0; cmp_b = '0; dst_t = '0; dst_f = '0;
    rd_idx = '0; issue_valid = '0;
  endtask

  task automatic set_port(input int p, input logic [31:0] a, input logic [31:0] b,
                          input int t, input int f);
    cmp_valid[p] = 1'b1; cmp_a[p] = a; cmp_b[p] = b;
    dst_t[p] = IW'(t); dst_f[p] = IW'(f);
  endtask

  // one accepting edge, then back at the falling edge with compares removed
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_valid = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic v;
    idle_inputs();
    for (int i = 0; i < NP; i++) model[i] = (i == 0);
    #(CLK_PERIOD * 2);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 reset state
    rd(0, v);  check(v, 1'b1, "R6 flag0 after reset");
    rd(5, v);  check(v, 1'b0, "R6 flag5 after reset");
    rd(63, v); check(v, 1'b0, "R6 flag63 after reset");

    // R1/R2 table on port 0
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a, b;
      int t, f;
      logic e;
      a = VEC[i][75:44]; b = VEC[i][43:12];
      t = int'(VEC[i][11:6]); f = int'(VEC[i][5:0]);
      e = (a == b);
      set_port(0, a, b, t, f);
      tick();
      if (f != 0) model[f] = ~e;
      if (t != 0) model[t] = e;
      rd(t, v); check(v, model[t], $sformatf("R1 vec%0d true dest %0d", i, t));
      rd(f, v); check(v, model[f], $sformatf("R1 vec%0d false dest %0d", i, f));
    end
    rd(0, v); check(v, 1'b1, "R2 flag0 after discarded writes");

    // R7 read during write cycle sees old value (flag1 is 0 after vec1)
    set_port(0, 32'h9, 32'h9, 1, 3);
    rd(1, v); check(v, 1'b0, "R7 old value in write cycle");
    tick();
    rd(1, v); check(v, 1'b1, "R7 new value next cycle");

    // R4 four independent compares
    set_port(0, 32'd1, 32'd1, 30, 31);
    set_port(1, 32'd1, 32'd2, 32, 33);
    set_port(2, 32'd3, 32'd3, 34, 35);
    set_port(3, 32'd4, 32'd5, 36, 37);
    tick();
    rd(30, v); check(v, 1'b1, "R4 p0 true");
    rd(31, v); check(v, 1'b0, "R4 p0 false");
    rd(32, v); check(v, 1'b0, "R4 p1 true");
    rd(33, v); check(v, 1'b1, "R4 p1 false");
    rd(34, v); check(v, 1'b1, "R4 p2 true");
    rd(35, v); check(v, 1'b0, "R4 p2 false");
    rd(36, v); check(v, 1'b0, "R4 p3 true");
    rd(37, v); check(v, 1'b1, "R4 p3 false");

    // R5 lower port wins: port1 writes 1 to flag40, port3 writes 0
    set_port(1, 32'd8, 32'd8, 40, 0);
    set_port(3, 32'd8, 32'd9, 40, 0);
    tick();
    rd(40, v); check(v, 1'b1, "R5 port1 over port3");
    // port0 writes 0, port2 writes 1 to flag41
    set_port(0, 32'd1, 32'd2, 41, 0);
    set_port(2, 32'd5, 32'd5, 41, 0);
    tick();
    rd(41, v); check(v, 1'b0, "R5 port0 over port2");
    // within a port the true destination wins
    set_port(2, 32'd6, 32'd6, 42, 42);
    tick();
    rd(42, v); check(v, 1'b1, "R5 true over false same port");

    // R8 untouched flags keep value, idle cycle changes nothing
    rd(30, v); check(v, 1'b1, "R8 flag30 kept");
    rd(63, v); check(v, 1'b0, "R8 flag63 kept");
    tick();
    rd(34, v); check(v, 1'b1, "R8 idle cycle keeps flag34");

    // R3 commit gating (flag30=1, flag31=0)
    rd_idx[0] = 6'd30; rd_idx[1] = 6'd31; rd_idx[2] = 6'd0;
    issue_valid = 4'b0111;
    #1;
    check(commit_en[0], 1'b1, "R3 valid and true");
    check(commit_en[1], 1'b0, "R3 valid and false");
    check(commit_en[2], 1'b1, "R3 flag0 always commits");
    issue_valid = 4'b0000;
    #1;
    check(commit_en[0], 1'b0, "R3 no issue no commit");

    // R6 reset again clears flags
    rst_n = 1'b0;
    #1;
    rd(30, v); check(v, 1'b0, "R6 flag30 cleared by reset");
    rd(0, v);  check(v, 1'b1, "R6 flag0 true in reset");
    @(negedge clk);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule